// File: doc/BRIEF.md
# Keyed-Restart Watchdog Countdown Timer

This block is a countdown watchdog. It sits on a simple 32-bit register bus with an address, a write strobe, write data and registered read data. Software loads a reload value and enables counting. It must then keep writing a fixed key word to the restart register before the counter runs out.

The counter moves down on each 1 MHz tick enable, or on every clock if software selects that. A step taken while the counter is at zero is an expiry. An expiry reloads the counter and raises three one-cycle pulses, each gated by its own enable bit: an interrupt, a reset request and an external trigger. The reset request carries a 2-bit reset kind.

A sticky status word records every expiry. It also records whether the secondary boot source was selected when the expiry happened. Software clears each status bit by writing a 1 to it.

Top module: `wdog_keyed`

## Requirements
- R1: After the synchronous reset the reload register reads 0x03EF1480, the control register reads 0, the count reads 0x03EF1480, the status word reads 0, and all event outputs are low.
- R2: The registers sit at word-aligned byte offsets. 0x00 is the current count (read only). 0x04 is the reload value. 0x08 is restart (reads 0). 0x0C is control (bits 7:0 stored, bits 31:8 read 0). 0x10 is timeout status. Any other or unaligned address reads 0 and ignores writes. Read data appears one clock after the address is presented.
- R3: Writing exactly 0x00004755 to offset 0x08 copies the reload value into the counter. Any other value written there leaves the count unchanged.
- R4: Control bit 0 enables counting. With bit 4 set, the counter steps only in cycles where tick_1us is high. With bit 4 clear, it steps on every clock. With bit 0 clear, the count holds.
- R5: A step taken at count 0 is an expiry and reloads the counter. A step at a non-zero count decrements it. One period therefore lasts reload+1 steps.
- R6: In the cycle after an expiry edge, wd_irq, wd_reset_req and wd_ext_trig each pulse high if control bit 2, bit 1 and bit 3 respectively are set. Otherwise they stay low.
- R7: At each expiry, wd_reset_kind takes control bits 6:5 and holds them until the next expiry. The encodings are 00 = SoC, 01 = full chip and 10 = CPU only.
- R8: Status bit 0 is set by any expiry. Status bit 1 is set by an expiry while control bit 7 (secondary boot) is set. Writing 1 to a status bit clears it. A set in the same cycle wins over the clear.
- R9: A valid restart in the same cycle as a step loads the reload value, and no decrement or expiry happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | 1 MHz count enable, one clock wide |
| bus_addr | input | 5 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wd_irq | output | 1 | Expiry interrupt pulse |
| wd_reset_req | output | 1 | Expiry reset request pulse |
| wd_reset_kind | output | 2 | Reset kind captured at the last expiry |
| wd_ext_trig | output | 1 | Expiry external trigger pulse |

## Verification
A corrupt count shows in two ways. It reads back wrong at offset 0x00 on the next read. It also moves the next expiry pulse by as many steps as the error. With the bench driving the tick, each step is one exactly placed cycle. A wrong control or status value shows one clock after its address is read. A missed gating of an event shows in the very cycle after the expiry edge. Restart-versus-step priority is exposed by a restart write that lands on a tick: the two orders leave counts that differ by two.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // word indices (byte offset >> 2)
  localparam int unsigned IDX_COUNT   = 0;
  localparam int unsigned IDX_RELOAD  = 1;
  localparam int unsigned IDX_RESTART = 2;
  localparam int unsigned IDX_CTL     = 3;
  localparam int unsigned IDX_TSTAT   = 4;

  localparam int unsigned CTL_W   = 8;
  localparam int unsigned TSTAT_W = 2;

  // field order matches control bit positions 7..0
  typedef struct packed {
    logic       alt_boot;   // bit 7
    logic [1:0] rst_kind;   // bits 6:5
    logic       tick_sel;   // bit 4
    logic       ext_en;     // bit 3
    logic       irq_en;     // bit 2
    logic       rst_en;     // bit 1
    logic       run;        // bit 0
  } wd_ctl_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W      = 32,
  parameter logic [CNT_W-1:0] CNT_RST = 32'h03EF1480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_sel,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  timeunit 1ns;
  timeprecision 100ps;

  logic step;
  logic at_zero;

  assign step    = run && (tick_sel ? tick : 1'b1);
  assign at_zero = (count == '0);
  assign expire  = step && at_zero && !restart;

  always_ff @(posedge clk) begin
    if (rst)          count <= CNT_RST;
    else if (restart) count <= reload;
    else if (step)    count <= at_zero ? reload : count - CNT_W'(1);
  end

  // R4: no step and no restart leaves the count untouched
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(count));

  // R5: a step from a non-zero count lowers it by one
  a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
    (step && !restart && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  // R3 / R9: a keyed restart always lands the reload value
  a_r9_restart_wins: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count == $past(reload)));
endmodule

// File: rtl/wdog_events.sv
module wdog_events (
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  logic       irq_en,
  input  logic       rst_en,
  input  logic       ext_en,
  input  logic [1:0] kind_sel,
  output logic       irq,
  output logic       reset_req,
  output logic [1:0] reset_kind,
  output logic       ext_trig
);
  timeunit 1ns;
  timeprecision 100ps;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      reset_req  <= 1'b0;
      ext_trig   <= 1'b0;
      reset_kind <= 2'b00;
    end else begin
      irq       <= expire && irq_en;
      reset_req <= expire && rst_en;
      ext_trig  <= expire && ext_en;
      if (expire) reset_kind <= kind_sel;
    end
  end

  // R6: each pulse only follows an enabled expiry
  a_r6_reset_gated: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> ($past(expire) && $past(rst_en)));

  a_r6_ext_gated: assert property (@(posedge clk) disable iff (rst)
    ext_trig |-> ($past(expire) && $past(ext_en)));

  // R7: the kind only moves on an expiry
  a_r7_kind_held: assert property (@(posedge clk) disable iff (rst)
    !expire |=> $stable(reset_kind));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_4755
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output wd_ctl_t           ctl,
  output logic [CNT_W-1:0]  reload,
  output logic              restart,
  output logic [TSTAT_W-1:0] tstat
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic sel_count, sel_reload, sel_restart, sel_ctl, sel_tstat;
  logic [TSTAT_W-1:0] ts_clr, ts_set;

  assign idx         = addr[ADDR_W-1:2];
  assign aligned     = (addr[1:0] == 2'b00);
  assign sel_count   = aligned && (idx == IDX_W'(IDX_COUNT));
  assign sel_reload  = aligned && (idx == IDX_W'(IDX_RELOAD));
  assign sel_restart = aligned && (idx == IDX_W'(IDX_RESTART));
  assign sel_ctl     = aligned && (idx == IDX_W'(IDX_CTL));
  assign sel_tstat   = aligned && (idx == IDX_W'(IDX_TSTAT));

  assign restart = we && sel_restart && (wdata == KEY);
  assign ts_clr  = (we && sel_tstat) ? wdata[TSTAT_W-1:0] : '0;
  assign ts_set  = {expire && ctl.alt_boot, expire};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      reload <= RELOAD_RST;
      tstat  <= '0;
    end else begin
      if (we && sel_ctl)    ctl    <= wd_ctl_t'(wdata[CTL_W-1:0]);
      if (we && sel_reload) reload <= wdata[CNT_W-1:0];
      tstat <= (tstat & ~ts_clr) | ts_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      rdata <= '0;
      if (sel_count)  rdata <= DATA_W'(count);
      if (sel_reload) rdata <= DATA_W'(reload);
      if (sel_ctl)    rdata <= DATA_W'(ctl);
      if (sel_tstat)  rdata <= DATA_W'(tstat);
    end
  end

  // R8: the secondary-boot flag only rises for an expiry under alt boot
  a_r8_alt_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(tstat[1]) |-> ($past(expire) && $past(ctl.alt_boot)));

  // R8: an expiry always leaves status bit 0 set
  a_r8_any_flag: assert property (@(posedge clk) disable iff (rst)
    expire |=> tstat[0]);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter logic [CNT_W-1:0]  RELOAD_RST = 32'h03EF1480,
  parameter logic [DATA_W-1:0] KEY        = 32'h0000_4755
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1us,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_irq,
  output logic              wd_reset_req,
  output logic [1:0]        wd_reset_kind,
  output logic              wd_ext_trig
);
  timeunit 1ns;
  timeprecision 100ps;

  wd_ctl_t            ctl;
  logic [CNT_W-1:0]   reload;
  logic [CNT_W-1:0]   count;
  logic               restart;
  logic               expire;
  logic [TSTAT_W-1:0] tstat;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .RELOAD_RST(RELOAD_RST), .KEY(KEY)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .count(count), .expire(expire), .rdata(bus_rdata), .ctl(ctl),
    .reload(reload), .restart(restart), .tstat(tstat)
  );

  wdog_counter #(.CNT_W(CNT_W), .CNT_RST(RELOAD_RST)) u_cnt (
    .clk(clk), .rst(rst), .run(ctl.run), .tick_sel(ctl.tick_sel),
    .tick(tick_1us), .restart(restart), .reload(reload),
    .count(count), .expire(expire)
  );

  wdog_events u_evt (
    .clk(clk), .rst(rst), .expire(expire),
    .irq_en(ctl.irq_en), .rst_en(ctl.rst_en), .ext_en(ctl.ext_en),
    .kind_sel(ctl.rst_kind), .irq(wd_irq), .reset_req(wd_reset_req),
    .reset_kind(wd_reset_kind), .ext_trig(wd_ext_trig)
  );

  // R6 / R8: an interrupt pulse always coincides with a recorded expiry
  a_r6_irq_recorded: assert property (@(posedge clk) disable iff (rst)
    wd_irq |-> tstat[0]);

  // R5: an expiry never leaves the counter at a value other than the reload
  a_r5_expiry_reload: assert property (@(posedge clk) disable iff (rst)
    expire |=> (count == $past(reload)));
endmodule

// File: tb/sim_wdog_keyed.sv
module sim_wdog_keyed;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1us = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_irq, wd_reset_req, wd_ext_trig;
  logic [1:0]  wd_reset_kind;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  wdog_keyed u0 (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .wd_reset_req(wd_reset_req),
    .wd_reset_kind(wd_reset_kind), .wd_ext_trig(wd_ext_trig)
  );

  localparam logic [31:0] KEY = 32'h0000_4755;
  localparam logic [3:0] OP_WR = 4'd1, OP_RD = 4'd2, OP_TK = 4'd3;
  localparam int N_VEC = 24;
  // {req, op, addr, data, expected}
  localparam logic [79:0] VEC [0:N_VEC-1] = '{
    {4'd1, OP_RD, 8'h04, 32'h0,         32'h03EF1480}, // R1 reload
    {4'd1, OP_RD, 8'h0C, 32'h0,         32'h0},        // R1 control
    {4'd1, OP_RD, 8'h00, 32'h0,         32'h03EF1480}, // R1 count
    {4'd1, OP_RD, 8'h10, 32'h0,         32'h0},        // R1 status
    {4'd2, OP_WR, 8'h0C, 32'hFFFFFF00, 32'h0},
    {4'd2, OP_RD, 8'h0C, 32'h0,         32'h0},        // R2 upper control bits dropped
    {4'd2, OP_RD, 8'h08, 32'h0,         32'h0},        // R2 restart reads 0
    {4'd2, OP_RD, 8'h14, 32'h0,         32'h0},        // R2 unmapped
    {4'd2, OP_WR, 8'h05, 32'h0000_0009, 32'h0},        // R2 unaligned write ignored
    {4'd2, OP_RD, 8'h04, 32'h0,         32'h03EF1480},
    {4'd2, OP_WR, 8'h04, 32'h0000_0005, 32'h0},
    {4'd2, OP_RD, 8'h04, 32'h0,         32'h5},
    {4'd3, OP_WR, 8'h08, 32'h0000_4756, 32'h0},
    {4'd3, OP_RD, 8'h00, 32'h0,         32'h03EF1480}, // R3 wrong key
    {4'd3, OP_WR, 8'h08, 32'h0001_4755, 32'h0},
    {4'd3, OP_RD, 8'h00, 32'h0,         32'h03EF1480}, // R3 upper bits spoil key
    {4'd3, OP_WR, 8'h08, KEY,           32'h0},
    {4'd3, OP_RD, 8'h00, 32'h0,         32'h5},        // R3 keyed reload
    {4'd4, OP_WR, 8'h0C, 32'h0000_0010, 32'h0},
    {4'd4, OP_TK, 8'h00, 32'h0,         32'h0},
    {4'd4, OP_RD, 8'h00, 32'h0,         32'h5},        // R4 not running holds
    {4'd4, OP_WR, 8'h0C, 32'h0000_0011, 32'h0},
    {4'd4, OP_TK, 8'h00, 32'h0,         32'h0},
    {4'd4, OP_RD, 8'h00, 32'h0,         32'h4}         // R4 tick step
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  task automatic tick();
    tick_1us = 1'b1;
    @(negedge clk);
    tick_1us = 1'b0;
  endtask

  task automatic events(input string req, input logic [4:0] exp);
    check(req, {27'b0, wd_irq, wd_reset_req, wd_ext_trig, wd_reset_kind}, {27'b0, exp});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int gap;
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    events("R1 outputs", 5'b00000);

    for (int i = 0; i < N_VEC; i++) begin
      logic [79:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[79:76], i);
      case (v[75:72])
        OP_WR: wr(v[68:64], v[63:32]);
        OP_RD: rd(tag, v[68:64], v[31:0]);
        default: tick();
      endcase
    end

    // R5 R6 R7 R8: full expiry with every event, CPU kind, alt boot
    wr(5'h0C, 32'h0); wr(5'h04, 32'h2); wr(5'h08, KEY); wr(5'h0C, 32'hDF);
    tick(); tick();
    events("R6 no pulse before expiry", 5'b00000);
    tick();
    events("R6 R7 expiry pulses kind 10", 5'b11110);
    @(negedge clk);
    events("R6 one-cycle pulse R7 kind held", 5'b00010);
    rd("R5 reload after expiry", 5'h00, 32'h2);
    rd("R8 both flags", 5'h10, 32'h3);
    wr(5'h10, 32'h1);
    rd("R8 clear bit0", 5'h10, 32'h2);
    wr(5'h10, 32'h2);
    rd("R8 clear bit1", 5'h10, 32'h0);

    // R6 R8: expiry with all events disabled, no alt boot
    wr(5'h0C, 32'h0); wr(5'h04, 32'h0); wr(5'h08, KEY); wr(5'h0C, 32'h11);
    tick();
    events("R6 gated off, R7 kind 00", 5'b00000);
    rd("R8 only bit0", 5'h10, 32'h1);

    // R7: reset request with full-chip kind
    wr(5'h0C, 32'h33);
    tick();
    events("R7 kind 01 reset only", 5'b01001);

    // R4 R5: per-clock counting, period reload+1
    wr(5'h0C, 32'h0); wr(5'h04, 32'h3); wr(5'h08, KEY); wr(5'h0C, 32'h05);
    for (int p = 0; p < 2; p++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!wd_irq && gap < 50);
      check($sformatf("R5 R4 per-clock period %0d", p), gap, 4);
    end
    wr(5'h0C, 32'h0);
    bus_addr = 5'h00;
    @(negedge clk);
    snap = bus_rdata;
    repeat (3) @(negedge clk);
    check("R4 stopped count holds", bus_rdata, snap);

    // R9: restart coinciding with a tick
    wr(5'h04, 32'h7); wr(5'h08, KEY); wr(5'h0C, 32'h11);
    tick();
    rd("R5 step 7->6", 5'h00, 32'h6);
    bus_addr = 5'h08; bus_wdata = KEY; bus_we = 1'b1; tick_1us = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_1us = 1'b0;
    rd("R9 restart wins over step", 5'h00, 32'h7);

    // R1: reset in mid-run
    wr(5'h0C, 32'hDF); wr(5'h04, 32'h0); wr(5'h08, KEY); tick();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    events("R1 outputs after reset", 5'b00000);
    rd("R1 reload after reset", 5'h04, 32'h03EF1480);
    rd("R1 control after reset", 5'h0C, 32'h0);
    rd("R1 count after reset", 5'h00, 32'h03EF1480);
    rd("R1 status after reset", 5'h10, 32'h0);

    finish_run();
  end
endmodule